// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker

This block sits between the memory fetch path of a display controller and the panel data pins. It takes 32-bit words read from the frame buffer through a ready/valid handshake, keeps them in an eight-byte staging register, and slices out one pixel each time the timing logic raises a pixel strobe. Each pixel is placed on a 24-bit lane bus that carries red, green and blue.

Three storage formats are supported:
- 24-bit with one pixel per word and a spare byte.
- 24-bit packed, where the bytes of a pixel may fall in two different words.
- 16-bit, with 5-bit components and one intensity bit.

An optional swap exchanges the red and blue lanes, so a panel wired for the opposite colour order can be driven without reordering in software. Panels with fewer than eight bits per colour connect to the upper bits of each lane.

If a pixel is requested when not enough data is staged, the block drives black and raises a sticky underrun flag. A frame-start pulse clears the flag and discards partly consumed data, so that packed streams realign at every frame.

Top module: `pixel_unpacker`

## Requirements
- R1: `fmt` selects the format: 0 = 24-bit one pixel per word, 1 = 24-bit packed, 2 = 16-bit, 3 behaves as 0. In format 0 a word carries red in bits 7:0, green in 15:8 and blue in 23:16. Bits 31:24 are ignored. Output lanes are `pix_data[7:0]` red, `[15:8]` green and `[23:16]` blue when `swap_rb` is 0.
- R2: A word is taken at a clock edge where `word_valid` and `word_ready` are both high. `word_ready` is high exactly when at most 4 bytes are staged and `frame_start` is low. Staging holds 8 bytes, so `word_ready` is low after two words are staged and no pixel has been drawn.
- R3: In format 1 the words form a little-endian byte stream. Each pixel is three consecutive bytes in the order red, green, blue. Three words therefore carry four pixels, and pixels cross word boundaries.
- R4: In format 2 each word carries two pixels, and the low halfword is emitted first. A halfword has red in bits 4:0, green in 9:5, blue in 14:10 and intensity in bit 15.
- R5: In format 2 each 5-bit component drives the top five bits of its lane (bits 7:3, 15:11, 23:19). The intensity bit drives bits 2, 10 and 18. Bits 1:0, 9:8 and 17:16 are zero.
- R6: With `swap_rb` = 1 the red and blue lanes are exchanged: red appears on bits 23:16 and blue on bits 7:0. Green is unchanged.
- R7: A high `pix_req` at a clock edge updates `pix_data` at that edge with the next pixel. If fewer bytes than one pixel needs are staged at that edge, `pix_data` becomes 0, `underrun` becomes 1 and nothing is consumed. A word accepted at the same edge is not used for that request.
- R8: `underrun` stays high until a clock edge with `frame_start` high, which clears it. The same edge empties the staging register, so earlier staged bytes are never emitted.
- R9: Without `pix_req`, `pix_data` holds its value.
- R10: After reset, `pix_data` is 0, `underrun` is 0, staging is empty and `word_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Pixel storage format code |
| swap_rb | input | 1 | Exchange red and blue output lanes |
| frame_start | input | 1 | Clears underrun and empties staging |
| word_data | input | 32 | Frame buffer word |
| word_valid | input | 1 | Word present |
| word_ready | output | 1 | Block can take a word |
| pix_req | input | 1 | Pixel strobe |
| pix_data | output | 24 | Panel lane bus |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The hardest situations to reach are the packed mode and the flush. In packed mode, a pixel's bytes lie in two words, and staging is shallower than the three-word cycle. The stimulus therefore interleaves word pushes with pixel strobes in an exact order, so that every one of the four byte alignments is consumed while the register is partly full. The flush is shown by staging a word, pulsing frame start, and then requesting a pixel. Only a fresh underrun with black output reveals that the staged bytes were discarded.

// File: rtl/pixel_unpacker.sv
module pixel_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic        swap_rb,
  input  logic        frame_start,
  input  logic [31:0] word_data,
  input  logic        word_valid,
  output logic        word_ready,
  input  logic        pix_req,
  output logic [23:0] pix_data,
  output logic        underrun
);

  localparam logic [1:0] FMT_PACKED = 2'd1;
  localparam logic [1:0] FMT_HALF   = 2'd2;

  logic [63:0] stash, shifted, stash_n;
  logic [3:0]  fill, need, remain, fill_n;
  logic        have, take, accept;
  logic [7:0]  red, green, blue;
  logic [15:0] half;
  logic [23:0] lanes;

  always_comb begin
    case (fmt)
      FMT_PACKED: need = 4'd3;
      FMT_HALF:   need = 4'd2;
      default:    need = 4'd4;
    endcase
  end

  assign have       = fill >= need;
  assign take       = pix_req && have;
  assign word_ready = (fill <= 4'd4) && !frame_start;
  assign accept     = word_valid && word_ready;

  assign remain  = take ? fill - need : fill;
  assign shifted = take ? stash >> {need, 3'b000} : stash;
  assign stash_n = accept ? (shifted | ({32'd0, word_data} << {remain, 3'b000})) : shifted;
  assign fill_n  = remain + (accept ? 4'd4 : 4'd0);

  assign half = stash[15:0];

  always_comb begin
    if (fmt == FMT_HALF) begin
      red   = {half[4:0],   half[15], 2'b00};
      green = {half[9:5],   half[15], 2'b00};
      blue  = {half[14:10], half[15], 2'b00};
    end else begin
      red   = stash[7:0];
      green = stash[15:8];
      blue  = stash[23:16];
    end
  end

  assign lanes = swap_rb ? {red, green, blue} : {blue, green, red};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stash <= '0;
      fill  <= '0;
    end else if (frame_start) begin
      stash <= '0;
      fill  <= '0;
    end else begin
      stash <= stash_n;
      fill  <= fill_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pix_data <= '0;
    else if (pix_req) pix_data <= have ? lanes : 24'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                underrun <= 1'b0;
    else if (frame_start)      underrun <= 1'b0;
    else if (pix_req && !have) underrun <= 1'b1;
  end

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 4'd8);

  a_r7_rise_on_starve: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(pix_req) && pix_data == 24'd0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !frame_start) |=> underrun);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !underrun);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> $stable(pix_data));

endmodule

// File: tb/pixel_unpacker_test.sv
`timescale 1ns/1ps
module pixel_unpacker_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  fmt = 2'd0;
  logic        swap_rb = 0;
  logic        frame_start = 0;
  logic [31:0] word_data = '0;
  logic        word_valid = 0;
  logic        word_ready;
  logic        pix_req = 0;
  logic [23:0] pix_data;
  logic        underrun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  pixel_unpacker uut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .swap_rb(swap_rb),
    .frame_start(frame_start), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .pix_req(pix_req), .pix_data(pix_data),
    .underrun(underrun)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] rgb(input logic [7:0] r, input logic [7:0] g,
                                      input logic [7:0] b, input logic sw);
    return sw ? {r, g, b} : {b, g, r};
  endfunction

  function automatic logic [23:0] hw(input logic [15:0] h, input logic sw);
    return rgb({h[4:0], h[15], 2'b00}, {h[9:5], h[15], 2'b00},
               {h[14:10], h[15], 2'b00}, sw);
  endfunction

  task automatic push(input logic [31:0] w);
    while (!word_ready) @(negedge clk);
    word_valid = 1;
    word_data  = w;
    @(negedge clk);
    word_valid = 0;
  endtask

  task automatic req(input logic [23:0] exp, input string tag);
    pix_req = 1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    pix_req = 0;
  endtask

  task automatic new_frame();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  always begin
    logic r;
    @(posedge clk);
    r = pix_req;
    @(negedge clk);
    if (r) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 1, 0);
      else chk(tag_q.pop_front(), {8'd0, pix_data}, {8'd0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lo, hi;
    repeat (3) @(negedge clk);
    chk("R10 pix_data", {8'd0, pix_data}, 0);
    chk("R10 underrun", {31'd0, underrun}, 0);
    chk("R10 ready", {31'd0, word_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    fmt = 2'd0;
    push(32'hAA332211);
    push(32'h00665544);
    chk("R2 ready low when full", {31'd0, word_ready}, 0);
    req(rgb(8'h11, 8'h22, 8'h33, 0), "R1 unpacked pixel0");
    req(rgb(8'h44, 8'h55, 8'h66, 0), "R1 unpacked pixel1");
    chk("R2 ready after drain", {31'd0, word_ready}, 1);

    swap_rb = 1;
    push(32'hFFC3B2A1);
    req(rgb(8'hA1, 8'hB2, 8'hC3, 1), "R6 swap 24-bit");
    repeat (3) @(negedge clk);
    chk("R9 hold", {8'd0, pix_data}, {8'd0, rgb(8'hA1, 8'hB2, 8'hC3, 1)});

    swap_rb = 0;
    fmt = 2'd3;
    push(32'h5F7E8D9C);
    req(rgb(8'h9C, 8'h8D, 8'h7E, 0), "R1 code3 as unpacked");

    new_frame();
    fmt = 2'd1;
    push(32'h44332211);
    push(32'h88776655);
    req(rgb(8'h11, 8'h22, 8'h33, 0), "R3 packed pixel0");
    req(rgb(8'h44, 8'h55, 8'h66, 0), "R3 packed pixel1");
    push(32'hCCBBAA99);
    req(rgb(8'h77, 8'h88, 8'h99, 0), "R3 packed pixel2");
    req(rgb(8'hAA, 8'hBB, 8'hCC, 0), "R3 packed pixel3");
    chk("R3 no starve", {31'd0, underrun}, 0);

    new_frame();
    fmt = 2'd2;
    lo = {1'b1, 5'h15, 5'h0A, 5'h13};
    hi = {1'b0, 5'h03, 5'h1C, 5'h08};
    push({hi, lo});
    req(hw(lo, 0), "R4 R5 low half first");
    req(hw(hi, 0), "R4 R5 high half");
    swap_rb = 1;
    push({hi, lo});
    req(hw(lo, 1), "R6 swap 16-bit low");
    req(hw(hi, 1), "R6 swap 16-bit high");
    swap_rb = 0;
    push({16'h8000, 16'h0000});
    req(24'd0, "R5 zero pixel");
    req(24'h040404, "R5 intensity only");

    fmt = 2'd0;
    req(24'd0, "R7 starved pixel is zero");
    chk("R7 underrun set", {31'd0, underrun}, 1);
    push(32'h00030201);
    req(rgb(8'h01, 8'h02, 8'h03, 0), "R7 recovers data");
    chk("R8 underrun sticky", {31'd0, underrun}, 1);
    new_frame();
    chk("R8 underrun cleared", {31'd0, underrun}, 0);

    push(32'h00ABCDEF);
    new_frame();
    req(24'd0, "R8 flush discards staged word");
    chk("R8 underrun after flush", {31'd0, underrun}, 1);

    pix_req = 1;
    word_valid = 1;
    word_data = 32'h00123456;
    exp_q.push_back(24'd0);
    tag_q.push_back("R7 same-edge word not used");
    @(negedge clk);
    pix_req = 0;
    word_valid = 0;
    req(rgb(8'h56, 8'h34, 8'h12, 0), "R7 word used next request");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule